// File: doc/BRIEF.md
# Repetition-Interval Sequence Controller

This block times a single repetition interval of a pulse sequence inside one module of an instrument. A rising edge on a synchronous master sync input starts an interval. The block then counts qualified sample ticks from zero. It walks a small descriptor table of element windows, and each window has a start time, a length and a kind (transmit, receive or gradient playback). On every sample tick that lands inside the current window, the block raises a transfer request toward a DMA engine and tags it with the window kind. When the last window has finished, the block goes back to idle and waits for the next sync edge.

The host can stream intervals. In that case each interval it finishes loading is reported with a strobe, which adds one credit. Each accepted sync edge in streaming mode uses up one credit. If a sync edge arrives with no credit left, the block enters a stopped state instead of starting an interval that is only partly loaded. In batch mode the whole scan is preloaded, so credits are not consulted. Pause freezes the interval in place. Halt stops the block at any moment, and an arm strobe brings it back from the stopped state.

Top module: `tr_seq_ctrl`

## Requirements
- R1: After reset the block is idle: busy_o, stopped_o, overrun_o and dma_req_o are 0, credit_o is 0 and dma_kind_o is 0.
- R2: In idle, a sync_i edge (sync_i high in a cycle where it was low in the previous cycle) is accepted when halt_i is low and either batch_i is 1 or credit_o is non-zero. From the next cycle busy_o is 1 and the tick count restarts at 0.
- R3: Number the qualified ticks after acceptance n = 0, 1, 2 and so on. At tick n, dma_req_o is 1 exactly when start <= n < start+len for some loaded element. In that same cycle dma_kind_o carries that element's kind, encoded tx=01, rx=10, gradient=11. dma_kind_o is 00 whenever dma_req_o is 0. Elements are written at table index 0..elem_cnt_i-1, sorted by start, do not overlap, have len >= 1, and elem_cnt_i is 1..8.
- R4: In a cycle with tick_i low, dma_req_o is 0 and the tick count does not advance.
- R5: Right after the final tick of the last element, busy_o returns to 0.
- R6: A sync edge while busy is ignored: the interval and its requests are unchanged. It sets overrun_o, which stays at 1 until arm_i.
- R7: credit_o rises by 1 for each loaded_i strobe and saturates at 2^CREDIT_W-1. It falls by 1 for each sync edge accepted in streaming mode (batch_i=0). If both happen in the same cycle, credit_o is unchanged.
- R8: In streaming mode, a sync edge in idle with credit_o=0 sets stopped_o, starts no interval and produces no requests. While stopped, sync edges are ignored.
- R9: In batch mode, sync edges are accepted whatever the credit, and credit_o does not change.
- R10: While pause_i is high, ticks produce no request and do not advance the count. When pause_i drops, the interval resumes at the same tick number.
- R11: halt_i moves the block to stopped from any state in the next cycle, with no further requests. arm_i leaves stopped for idle and clears overrun_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Sample tick qualifier |
| sync_i | input | 1 | Master sync level, synchronous to clk_i |
| batch_i | input | 1 | 1 = batch mode, 0 = streaming mode |
| pause_i | input | 1 | Freeze the running interval |
| halt_i | input | 1 | Force the stopped state |
| arm_i | input | 1 | Leave stopped, clear overrun |
| loaded_i | input | 1 | Host strobe: one more interval loaded |
| desc_we_i | input | 1 | Descriptor write enable |
| desc_idx_i | input | IW (3) | Descriptor index |
| desc_start_i | input | 24 | Element start tick |
| desc_len_i | input | 24 | Element length in ticks |
| desc_kind_i | input | 2 | Element kind |
| elem_cnt_i | input | IW+1 (4) | Number of elements in the interval |
| dma_req_o | output | 1 | Transfer request for this tick |
| dma_kind_o | output | 2 | Kind of the requesting element |
| elem_idx_o | output | IW (3) | Current element index |
| busy_o | output | 1 | Interval running |
| stopped_o | output | 1 | Stopped state |
| overrun_o | output | 1 | Sticky: sync seen while busy |
| credit_o | output | CREDIT_W (4) | Loaded-interval credits |

## Verification
The window walk is swept over eight generated tables, from one element up to eight. Gaps of zero, one and two ticks between elements are mixed, so windows that touch can be told apart from windows separated by idle ticks, and an element that starts at tick 0 is covered. Every element kind appears. Every tick is preceded by a cycle without a tick, so a count that advances on the clock instead of on the tick would show up. Pauses in the middle of an interval and a sync that lands while busy test that the window sequence stays exactly as computed. The credit runs exercise several situations and tell them apart by whether an interval starts or the block stops: two preloaded intervals, a starved edge, a strobe that coincides with a sync, saturation, and batch mode with zero credit.

// File: rtl/tr_seq_pkg.sv
package tr_seq_pkg;
  parameter int TIME_W = 24;

  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_TX   = 2'b01,
    KIND_RX   = 2'b10,
    KIND_GRAD = 2'b11
  } elem_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_STOP = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [TIME_W-1:0] start;
    logic [TIME_W-1:0] len;
    elem_kind_e        kind;
  } elem_desc_t;
endpackage

// File: rtl/tr_desc_table.sv
module tr_desc_table
  import tr_seq_pkg::*;
#(
  parameter int N_ELEM = 8,
  localparam int IW = (N_ELEM > 1) ? $clog2(N_ELEM) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  elem_desc_t    wdesc_i,
  input  logic [IW-1:0] ridx_i,
  output elem_desc_t    rdesc_o
);
  localparam int DW = $bits(elem_desc_t);

  logic [N_ELEM-1:0][DW-1:0] flat;

  for (genvar g = 0; g < N_ELEM; g++) begin : g_ent
    elem_desc_t ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              ent_q <= '0;
      else if (we_i && (widx_i == IW'(g)))      ent_q <= wdesc_i;
    end
    assign flat[g] = ent_q;
  end

  assign rdesc_o = elem_desc_t'(flat[ridx_i]);
endmodule

// File: rtl/tr_window_unit.sv
module tr_window_unit #(
  parameter int TW     = 24,
  parameter int N_ELEM = 8,
  localparam int IW = (N_ELEM > 1) ? $clog2(N_ELEM) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic          last_i,
  input  logic [TW-1:0] start_i,
  input  logic [TW-1:0] len_i,
  output logic [IW-1:0] ptr_o,
  output logic          in_win_o,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;
  logic [IW-1:0] ptr_q;
  logic [TW:0]   end_w;
  logic          fin;

  assign end_w    = {1'b0, start_i} + {1'b0, len_i};
  assign in_win_o = (cnt_q >= start_i) && ({1'b0, cnt_q} < end_w);
  // last tick of the current element
  assign fin      = (({1'b0, cnt_q} + (TW+1)'(1)) >= end_w);
  assign done_o   = adv_i && fin && last_i;
  assign ptr_o    = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ptr_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ptr_q <= '0;
    end else if (adv_i) begin
      cnt_q <= cnt_q + TW'(1);
      if (fin && !last_i) ptr_q <= ptr_q + IW'(1);
    end
  end

  a_r10_count_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(cnt_q));

  a_r2_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && ptr_q == '0));
endmodule

// File: rtl/tr_credit_ctr.sv
module tr_credit_ctr #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [CW-1:0] credit_o,
  output logic          zero_o
);
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  logic [CW-1:0] credit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) credit_q <= '0;
    else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (credit_q != MAXV) credit_q <= credit_q + CW'(1);
        2'b01:   if (credit_q != '0)   credit_q <= credit_q - CW'(1);
        default: ;
      endcase
    end
  end

  assign credit_o = credit_q;
  assign zero_o   = (credit_q == '0);

  a_r7_credit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (credit_q != $past(credit_q)) |->
      ((credit_q == $past(credit_q) + CW'(1)) || (credit_q == $past(credit_q) - CW'(1))));
endmodule

// File: rtl/tr_seq_ctrl.sv
module tr_seq_ctrl
  import tr_seq_pkg::*;
#(
  parameter int N_ELEM   = 8,
  parameter int CREDIT_W = 4,
  localparam int IW = (N_ELEM > 1) ? $clog2(N_ELEM) : 1,
  localparam int TW = TIME_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                sync_i,
  input  logic                batch_i,
  input  logic                pause_i,
  input  logic                halt_i,
  input  logic                arm_i,
  input  logic                loaded_i,
  input  logic                desc_we_i,
  input  logic [IW-1:0]       desc_idx_i,
  input  logic [TW-1:0]       desc_start_i,
  input  logic [TW-1:0]       desc_len_i,
  input  logic [1:0]          desc_kind_i,
  input  logic [IW:0]         elem_cnt_i,
  output logic                dma_req_o,
  output logic [1:0]          dma_kind_o,
  output logic [IW-1:0]       elem_idx_o,
  output logic                busy_o,
  output logic                stopped_o,
  output logic                overrun_o,
  output logic [CREDIT_W-1:0] credit_o
);
  seq_state_e    state_q, state_d;
  logic          sync_q, sync_edge;
  logic          overrun_q;
  logic          accept, starve, adv, done, in_win, last, cred_zero;
  logic [IW-1:0] ptr;
  logic [IW:0]   last_idx;
  elem_desc_t    wdesc, cur;

  assign wdesc = '{start: desc_start_i, len: desc_len_i, kind: elem_kind_e'(desc_kind_i)};

  tr_desc_table #(.N_ELEM(N_ELEM)) u_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (desc_we_i),
    .widx_i (desc_idx_i),
    .wdesc_i(wdesc),
    .ridx_i (ptr),
    .rdesc_o(cur)
  );

  assign last_idx = (elem_cnt_i == '0) ? '0 : elem_cnt_i - (IW+1)'(1);
  assign last     = (ptr == last_idx[IW-1:0]);

  tr_window_unit #(.TW(TW), .N_ELEM(N_ELEM)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .adv_i   (adv),
    .last_i  (last),
    .start_i (cur.start),
    .len_i   (cur.len),
    .ptr_o   (ptr),
    .in_win_o(in_win),
    .done_o  (done)
  );

  tr_credit_ctr #(.CW(CREDIT_W)) u_credit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (loaded_i),
    .dec_i   (accept && !batch_i),
    .credit_o(credit_o),
    .zero_o  (cred_zero)
  );

  assign sync_edge = sync_i && !sync_q;
  assign accept    = (state_q == ST_IDLE) && sync_edge && !halt_i && (batch_i || !cred_zero);
  assign starve    = (state_q == ST_IDLE) && sync_edge && !halt_i && !batch_i && cred_zero;
  assign adv       = (state_q == ST_RUN) && tick_i && !pause_i && !halt_i;

  always_comb begin
    state_d = state_q;
    if (halt_i) state_d = ST_STOP;
    else begin
      unique case (state_q)
        ST_IDLE: if (accept) state_d = ST_RUN;
                 else if (starve) state_d = ST_STOP;
        ST_RUN:  if (done) state_d = ST_IDLE;
        ST_STOP: if (arm_i) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sync_q    <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sync_q  <= sync_i;
      if ((state_q == ST_RUN) && sync_edge) overrun_q <= 1'b1;
      else if (arm_i)                       overrun_q <= 1'b0;
    end
  end

  assign dma_req_o  = adv && in_win;
  assign dma_kind_o = dma_req_o ? cur.kind : KIND_NONE;
  assign elem_idx_o = ptr;
  assign busy_o     = (state_q == ST_RUN);
  assign stopped_o  = (state_q == ST_STOP);
  assign overrun_o  = overrun_q;

  a_r3_req_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (tick_i && busy_o && !pause_i));

  a_r6_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !arm_i) |=> overrun_o);

  a_r8_starve_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && sync_edge && !batch_i && (credit_o == '0) && !halt_i) |=> stopped_o);

  a_r11_halt_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> (stopped_o && !busy_o));

  a_r4_no_req_idle_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |-> !dma_req_o);
endmodule

// File: tb/tr_seq_ctrl_tb_top.sv
module tr_seq_ctrl_tb_top;
  localparam int N_ELEM = 8;
  localparam int CW     = 4;
  localparam int IW     = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tick_i = 0, sync_i = 0, batch_i = 0, pause_i = 0, halt_i = 0;
  logic          arm_i = 0, loaded_i = 0, desc_we_i = 0;
  logic [IW-1:0] desc_idx_i = '0;
  logic [23:0]   desc_start_i = '0, desc_len_i = '0;
  logic [1:0]    desc_kind_i = '0;
  logic [IW:0]   elem_cnt_i = '0;
  logic          dma_req_o, busy_o, stopped_o, overrun_o;
  logic [1:0]    dma_kind_o;
  logic [IW-1:0] elem_idx_o;
  logic [CW-1:0] credit_o;

  int checks = 0;
  int errors = 0;
  int tb_n;
  int tb_start [8];
  int tb_len   [8];
  int tb_kind  [8];

  always #5 clk_i = ~clk_i;

  tr_seq_ctrl #(.N_ELEM(N_ELEM), .CREDIT_W(CW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .sync_i(sync_i),
    .batch_i(batch_i), .pause_i(pause_i), .halt_i(halt_i), .arm_i(arm_i),
    .loaded_i(loaded_i), .desc_we_i(desc_we_i), .desc_idx_i(desc_idx_i),
    .desc_start_i(desc_start_i), .desc_len_i(desc_len_i), .desc_kind_i(desc_kind_i),
    .elem_cnt_i(elem_cnt_i), .dma_req_o(dma_req_o), .dma_kind_o(dma_kind_o),
    .elem_idx_o(elem_idx_o), .busy_o(busy_o), .stopped_o(stopped_o),
    .overrun_o(overrun_o), .credit_o(credit_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic write_desc(input int i, input int s, input int l, input int k);
    desc_we_i = 1; desc_idx_i = IW'(i);
    desc_start_i = 24'(s); desc_len_i = 24'(l); desc_kind_i = 2'(k);
    step();
    desc_we_i = 0;
  endtask

  task automatic load_cfg(input int c);
    int prev = 0;
    tb_n = (c % 8) + 1;
    elem_cnt_i = (IW+1)'(tb_n);
    for (int i = 0; i < tb_n; i++) begin
      tb_start[i] = prev + ((i + c) % 3);
      tb_len[i]   = 1 + ((i * 3 + c) % 4);
      tb_kind[i]  = 1 + ((i + c) % 3);
      prev = tb_start[i] + tb_len[i];
      write_desc(i, tb_start[i], tb_len[i], tb_kind[i]);
    end
  endtask

  task automatic do_sync();
    sync_i = 1;
    step();
    sync_i = 0;
  endtask

  task automatic strobe_loaded(input int n);
    for (int i = 0; i < n; i++) begin
      loaded_i = 1;
      step();
    end
    loaded_i = 0;
  endtask

  // walk one accepted interval tick by tick; -1 disables pause / busy sync
  task automatic run_iv(input int pause_at, input int osync_at);
    int last_end = tb_start[tb_n-1] + tb_len[tb_n-1];
    for (int n = 0; n < last_end; n++) begin
      int ek = 0;
      if (n == osync_at) sync_i = 1;
      #1 chk("R4 no request without tick", int'(dma_req_o), 0);
      step();
      sync_i = 0;
      if (n == pause_at) begin
        pause_i = 1; tick_i = 1;
        for (int p = 0; p < 2; p++) begin
          #1 chk("R10 paused tick request", int'(dma_req_o), 0);
          step();
        end
        pause_i = 0;
      end
      for (int i = 0; i < tb_n; i++)
        if (n >= tb_start[i] && n < tb_start[i] + tb_len[i]) ek = tb_kind[i];
      tick_i = 1;
      #1;
      chk("R3 request at tick", int'(dma_req_o), (ek != 0) ? 1 : 0);
      chk("R3 kind at tick", int'(dma_kind_o), ek);
      step();
      tick_i = 0;
    end
    #1 chk("R5 idle after last element", int'(busy_o), 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 stopped", int'(stopped_o), 0);
    chk("R1 overrun", int'(overrun_o), 0);
    chk("R1 credit", int'(credit_o), 0);
    chk("R1 request", int'(dma_req_o), 0);
    chk("R1 kind", int'(dma_kind_o), 0);
    @(negedge clk_i);

    // streaming with two intervals loaded ahead
    batch_i = 0;
    load_cfg(2);
    strobe_loaded(2);
    chk("R7 credit after two strobes", int'(credit_o), 2);
    do_sync();
    chk("R2 busy after sync", int'(busy_o), 1);
    chk("R7 credit after accept", int'(credit_o), 1);
    run_iv(-1, 1);
    chk("R6 overrun set", int'(overrun_o), 1);
    do_sync();
    chk("R2 second interval busy", int'(busy_o), 1);
    chk("R7 credit drained", int'(credit_o), 0);
    run_iv(2, -1);
    chk("R6 overrun still set", int'(overrun_o), 1);

    // starved sync edge
    do_sync();
    chk("R8 stopped on zero credit", int'(stopped_o), 1);
    chk("R8 no interval started", int'(busy_o), 0);
    tick_i = 1;
    #1 chk("R8 no request when stopped", int'(dma_req_o), 0);
    step();
    tick_i = 0;
    strobe_loaded(1);
    do_sync();
    chk("R8 sync ignored while stopped", int'(stopped_o), 1);
    chk("R8 credit kept while stopped", int'(credit_o), 1);
    arm_i = 1;
    step();
    arm_i = 0;
    chk("R11 arm leaves stopped", int'(stopped_o), 0);
    chk("R11 arm clears overrun", int'(overrun_o), 0);

    // strobe and accepted sync in the same cycle
    loaded_i = 1;
    do_sync();
    loaded_i = 0;
    chk("R7 simultaneous strobe and sync", int'(credit_o), 1);
    chk("R2 accepted with strobe", int'(busy_o), 1);
    run_iv(-1, -1);

    strobe_loaded(20);
    chk("R7 credit saturates", int'(credit_o), 15);

    // batch sweep over eight tables
    batch_i = 1;
    for (int c = 0; c < 8; c++) begin
      load_cfg(c);
      do_sync();
      chk("R2 batch accept", int'(busy_o), 1);
      run_iv((c % 2 == 1) ? 1 : -1, -1);
      chk("R9 credit unchanged in batch", int'(credit_o), 15);
    end

    // batch with zero credit, then halt mid-interval
    rst_ni = 0;
    step();
    rst_ni = 1;
    step();
    batch_i = 1;
    load_cfg(5);
    do_sync();
    chk("R9 batch accepts with zero credit", int'(busy_o), 1);
    chk("R9 credit stays zero", int'(credit_o), 0);
    tick_i = 1;
    step();
    tick_i = 0;
    halt_i = 1;
    step();
    halt_i = 0;
    chk("R11 halt stops", int'(stopped_o), 1);
    chk("R11 halt clears busy", int'(busy_o), 0);
    tick_i = 1;
    #1 chk("R11 no request after halt", int'(dma_req_o), 0);
    step();
    tick_i = 0;
    arm_i = 1;
    step();
    arm_i = 0;
    chk("R11 arm to idle", int'(stopped_o), 0);
    halt_i = 1;
    step();
    halt_i = 0;
    chk("R11 halt from idle", int'(stopped_o), 1);

    finish_run();
  end
endmodule